// File: doc/BRIEF.md
# UART Channel FIFO Pair with Trigger Levels and Receive Timeout

This block buffers both directions of one UART channel. On the receive side, the serializer delivers bytes. Each byte arrives with three error status bits, and the host drains them. On the transmit side, the host loads plain bytes and the serializer drains them. Each side holds 32 entries when queueing is enabled. When queueing is off, each side holds a single entry.

A FIFO control write configures the block. The control byte sets:
- queueing on or off,
- one-shot flushes for each side,
- the DMA request style,
- a receive trigger level and a transmit trigger level.

The transmit trigger field is only held pending. It takes effect only while the enhanced-enable input is high. Otherwise the transmit side uses 16 free spaces. A character-time tick drives a receive timeout request, so that a few bytes below the trigger level still reach the host.

All four data interfaces are valid/ready:
- **Host transmit load:** it honours back-pressure. A byte is taken only in a cycle where `tx_in_valid` and `tx_in_ready` are both high.
- **Receive ingress:** it cannot stall the line. `rx_in_ready` only reports space. A byte offered while it is low is discarded and flagged.
- **Both drain interfaces:** a pop happens when ready is high while valid is high. Ready raised on an empty side is harmless.

Top module: `uart_chan_fifo`

## Requirements
- R1: With control bit 0 set, each side holds exactly 32 entries.
  - `tx_in_ready` is low when 32 bytes are held.
  - A receive byte offered with 32 held is dropped: the count stays 32 and the sticky `rx_overrun` is set.
- R2: With control bit 0 clear, each side is a one-entry holding register.
  - A side is full at 1 entry.
  - `rx_trig` is high at 1 entry and `tx_trig` is high only when the transmit side is empty.
  - A control write that changes bit 0 empties both sides.
- R3: Bytes leave in arrival order. Each receive entry returns its data on `rx_out_data` together with its three error bits on `rx_out_err`.
- R4: Control bits 7:6 select the receive trigger level: 00 = 8, 01 = 16, 10 = 24, 11 = 28 entries. In queue mode, `rx_trig` is high while the count is at or above that level.
- R5: The transmit trigger is a number of free spaces. Free spaces are 32 minus the fill.
  - Control bits 5:4 are stored as a pending choice: 00 = 16, 01 = 8, 10 = 24, 11 = 30.
  - The pending choice is used only while `enh_en` is 1. Otherwise the level is 16.
  - `tx_trig` is high while the free space is at or above the level.
- R6: Arming condition: the receive side holds data, is below its trigger level, and sees no push or pop.
  - While armed, four `char_tick` pulses raise `rx_tmo_irq` in the cycle after the fourth tick.
  - Any receive push or pop restarts the count.
  - A receive pop clears the request.
- R7: Control bit 3 selects the DMA request style.
  - When bit 3 is 0: `rx_dma_req` means the receive side is non-empty, and `tx_dma_req` means the transmit side is empty.
  - When bit 3 is 1: `rx_dma_req` is `rx_trig` or `rx_tmo_irq`, and `tx_dma_req` is `tx_trig`.
- R8: Flush bits are one-shot and leave the other side untouched.
  - Control bit 1 empties the receive side and clears `rx_overrun` and `rx_tmo_irq`.
  - Control bit 2 empties the transmit side.
  - A mode change counts as both flushes.
- R9: A pop on an empty side changes no count. The data output keeps showing the last byte popped.
- R10: After reset:
  - both counts are 0 and queueing is off;
  - `rx_trig`, `rx_tmo_irq` and `rx_overrun` are 0;
  - `tx_trig` is 1;
  - the transmit pending choice is 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fcr_wr | input | 1 | FIFO control write strobe |
| fcr_data | input | 8 | FIFO control byte |
| enh_en | input | 1 | Enhanced-enable: activates the pending transmit trigger |
| char_tick | input | 1 | One pulse per character time |
| rx_in_valid | input | 1 | Serializer offers a received byte |
| rx_in_ready | output | 1 | Receive side has space |
| rx_in_data | input | 8 | Received byte |
| rx_in_err | input | 3 | Error status of received byte |
| rx_out_valid | output | 1 | Receive side non-empty |
| rx_out_ready | input | 1 | Host pops a receive entry |
| rx_out_data | output | 8 | Head receive byte |
| rx_out_err | output | 3 | Head receive error bits |
| tx_in_valid | input | 1 | Host offers a transmit byte |
| tx_in_ready | output | 1 | Transmit side has space |
| tx_in_data | input | 8 | Transmit byte |
| tx_out_valid | output | 1 | Transmit side non-empty |
| tx_out_ready | input | 1 | Serializer pops a transmit byte |
| tx_out_data | output | 8 | Head transmit byte |
| rx_count | output | 6 | Receive fill |
| tx_count | output | 6 | Transmit fill |
| rx_trig | output | 1 | Receive trigger reached |
| tx_trig | output | 1 | Transmit free-space trigger reached |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_tmo_irq | output | 1 | Receive character timeout request |
| rx_overrun | output | 1 | Sticky receive overrun flag |

## Verification
The bench builds the block with its defaults: a depth of 32 and a timeout of 4 ticks. This puts every trigger choice, including the 28-entry and 30-free-space levels, and the full and overrun boundary within a few dozen pushes. The short timeout lets the request be reached, cleared by a pop and re-armed within a handful of tick pulses. The one-entry mode is covered directly after reset, which is when it is active.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;
  localparam int unsigned DW = 8;
  localparam int unsigned EW = 3;

  // bit positions inside the FIFO control byte
  localparam int unsigned CB_EN    = 0;
  localparam int unsigned CB_RXCLR = 1;
  localparam int unsigned CB_TXCLR = 2;
  localparam int unsigned CB_DMA   = 3;
  localparam int unsigned CB_TXLO  = 4;
  localparam int unsigned CB_RXLO  = 6;

  typedef struct packed {
    logic [EW-1:0] err;
    logic [DW-1:0] data;
  } rx_entry_t;
endpackage

// File: rtl/uart_fifo_store.sv
module uart_fifo_store #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 32,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          cap_one,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          push_fire,
  output logic          pop_fire
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [W-1:0]  last_q;

  assign empty     = (count == '0);
  assign full      = cap_one ? !empty : (count == CW'(DEPTH));
  assign push_fire = push && !full;
  assign pop_fire  = pop && !empty;
  assign dout      = empty ? last_q : mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_fire) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      last_q <= '0;
    end else begin
      if (pop_fire) last_q <= mem[rd_ptr];
      if (flush) begin
        wr_ptr <= '0;
        rd_ptr <= '0;
        count  <= '0;
      end else begin
        if (push_fire) wr_ptr <= wr_ptr + 1'b1;
        if (pop_fire)  rd_ptr <= rd_ptr + 1'b1;
        case ({push_fire, pop_fire})
          2'b10:   count <= count + 1'b1;
          2'b01:   count <= count - 1'b1;
          default: count <= count;
        endcase
      end
    end
  end

  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  p_single_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cap_one |-> count <= CW'(1));
  p_drop_when_full_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !flush) |=> $stable(count));
  p_empty_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push && !flush) |=> $stable(count) && $stable(dout));
endmodule

// File: rtl/uart_fifo_trig.sv
module uart_fifo_trig #(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic [1:0]    rx_sel,
  input  logic [1:0]    tx_pend,
  input  logic          enh_en,
  input  logic [CW-1:0] rx_count,
  input  logic [CW-1:0] tx_count,
  output logic          rx_trig,
  output logic          tx_trig,
  output logic          rx_armed
);
  localparam logic [CW-1:0] Q1  = CW'(DEPTH / 4);
  localparam logic [CW-1:0] Q2  = CW'(DEPTH / 2);
  localparam logic [CW-1:0] Q3  = CW'((3 * DEPTH) / 4);
  localparam logic [CW-1:0] R78 = CW'(DEPTH - DEPTH / 8);
  localparam logic [CW-1:0] T15 = CW'(DEPTH - DEPTH / 16);

  logic [CW-1:0] rx_lvl, tx_lvl, tx_free;
  logic [1:0]    tx_act;

  assign tx_act  = enh_en ? tx_pend : 2'b00;
  assign tx_free = CW'(DEPTH) - tx_count;

  always_comb begin
    case (rx_sel)
      2'b00:   rx_lvl = Q1;
      2'b01:   rx_lvl = Q2;
      2'b10:   rx_lvl = Q3;
      default: rx_lvl = R78;
    endcase
    case (tx_act)
      2'b00:   tx_lvl = Q2;
      2'b01:   tx_lvl = Q1;
      2'b10:   tx_lvl = Q3;
      default: tx_lvl = T15;
    endcase
  end

  assign rx_trig  = fifo_en ? (rx_count >= rx_lvl) : (rx_count != '0);
  assign tx_trig  = fifo_en ? (tx_free >= tx_lvl) : (tx_count == '0);
  assign rx_armed = (rx_count != '0) && !rx_trig;

  p_tx_default_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && !enh_en) |-> (tx_trig == (tx_count <= CW'(DEPTH / 2))));
endmodule

// File: rtl/uart_rx_timeout.sv
module uart_rx_timeout #(
  parameter int unsigned TMO_TICKS = 4,
  localparam int unsigned TW       = $clog2(TMO_TICKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic armed,
  input  logic push_fire,
  input  logic pop_fire,
  input  logic tick,
  output logic irq
);
  logic [TW-1:0] cnt;
  logic          restart;

  assign restart = flush || push_fire || pop_fire || !armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      irq <= 1'b0;
    end else begin
      if (flush || pop_fire) irq <= 1'b0;
      else if (!restart && tick && cnt == TW'(TMO_TICKS - 1)) irq <= 1'b1;
      if (restart) cnt <= '0;
      else if (tick && cnt != TW'(TMO_TICKS)) cnt <= cnt + 1'b1;
    end
  end

  p_pop_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pop_fire |=> !irq);
  p_rise_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(tick) && $past(armed));
endmodule

// File: rtl/uart_chan_fifo.sv
module uart_chan_fifo
  import uart_fifo_pkg::*;
#(
  parameter int unsigned DEPTH     = 32,
  parameter int unsigned TMO_TICKS = 4,
  localparam int unsigned CW       = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fcr_wr,
  input  logic [7:0]    fcr_data,
  input  logic          enh_en,
  input  logic          char_tick,
  input  logic          rx_in_valid,
  output logic          rx_in_ready,
  input  logic [DW-1:0] rx_in_data,
  input  logic [EW-1:0] rx_in_err,
  output logic          rx_out_valid,
  input  logic          rx_out_ready,
  output logic [DW-1:0] rx_out_data,
  output logic [EW-1:0] rx_out_err,
  input  logic          tx_in_valid,
  output logic          tx_in_ready,
  input  logic [DW-1:0] tx_in_data,
  output logic          tx_out_valid,
  input  logic          tx_out_ready,
  output logic [DW-1:0] tx_out_data,
  output logic [CW-1:0] rx_count,
  output logic [CW-1:0] tx_count,
  output logic          rx_trig,
  output logic          tx_trig,
  output logic          rx_dma_req,
  output logic          tx_dma_req,
  output logic          rx_tmo_irq,
  output logic          rx_overrun
);
  logic       fifo_en_q, dma_multi_q;
  logic [1:0] rx_sel_q, tx_pend_q;
  logic       mode_flip, rx_flush, tx_flush;
  logic       rx_full, rx_empty, rx_push_fire, rx_pop_fire;
  logic       tx_full, tx_empty, tx_push_fire, tx_pop_fire;
  logic       rx_armed;
  rx_entry_t  rx_din, rx_dout;

  assign mode_flip = fcr_wr && (fcr_data[CB_EN] != fifo_en_q);
  assign rx_flush  = (fcr_wr && fcr_data[CB_RXCLR]) || mode_flip;
  assign tx_flush  = (fcr_wr && fcr_data[CB_TXCLR]) || mode_flip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_en_q   <= 1'b0;
      dma_multi_q <= 1'b0;
      rx_sel_q    <= 2'b00;
      tx_pend_q   <= 2'b00;
      rx_overrun  <= 1'b0;
    end else begin
      if (fcr_wr) begin
        fifo_en_q   <= fcr_data[CB_EN];
        dma_multi_q <= fcr_data[CB_DMA];
        rx_sel_q    <= fcr_data[CB_RXLO +: 2];
        tx_pend_q   <= fcr_data[CB_TXLO +: 2];
      end
      if (rx_flush) rx_overrun <= 1'b0;
      else if (rx_in_valid && rx_full) rx_overrun <= 1'b1;
    end
  end

  assign rx_din = '{err: rx_in_err, data: rx_in_data};

  uart_fifo_store #(.W(DW + EW), .DEPTH(DEPTH)) rx_store_i (
    .clk, .rst_n, .flush(rx_flush), .cap_one(!fifo_en_q),
    .push(rx_in_valid), .pop(rx_out_ready), .din(rx_din), .dout(rx_dout),
    .count(rx_count), .full(rx_full), .empty(rx_empty),
    .push_fire(rx_push_fire), .pop_fire(rx_pop_fire)
  );

  uart_fifo_store #(.W(DW), .DEPTH(DEPTH)) tx_store_i (
    .clk, .rst_n, .flush(tx_flush), .cap_one(!fifo_en_q),
    .push(tx_in_valid), .pop(tx_out_ready), .din(tx_in_data), .dout(tx_out_data),
    .count(tx_count), .full(tx_full), .empty(tx_empty),
    .push_fire(tx_push_fire), .pop_fire(tx_pop_fire)
  );

  uart_fifo_trig #(.DEPTH(DEPTH)) trig_i (
    .clk, .rst_n, .fifo_en(fifo_en_q), .rx_sel(rx_sel_q), .tx_pend(tx_pend_q),
    .enh_en, .rx_count, .tx_count, .rx_trig, .tx_trig, .rx_armed
  );

  uart_rx_timeout #(.TMO_TICKS(TMO_TICKS)) tmo_i (
    .clk, .rst_n, .flush(rx_flush), .armed(rx_armed),
    .push_fire(rx_push_fire), .pop_fire(rx_pop_fire), .tick(char_tick), .irq(rx_tmo_irq)
  );

  assign rx_in_ready  = !rx_full;
  assign tx_in_ready  = !tx_full;
  assign rx_out_valid = !rx_empty;
  assign tx_out_valid = !tx_empty;
  assign rx_out_data  = rx_dout.data;
  assign rx_out_err   = rx_dout.err;
  assign rx_dma_req   = dma_multi_q ? (rx_trig || rx_tmo_irq) : !rx_empty;
  assign tx_dma_req   = dma_multi_q ? tx_trig : tx_empty;

  p_overrun_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_in_valid && !rx_in_ready && !rx_flush) |=> rx_overrun);
  p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush |=> (rx_count == '0) && !rx_overrun && !rx_tmo_irq);
  p_tx_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush |=> tx_count == '0);
endmodule

// File: tb/uart_chan_fifo_tb.sv
module uart_chan_fifo_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fcr_wr = 1'b0;
  logic [7:0] fcr_data = '0;
  logic       enh_en = 1'b0;
  logic       char_tick = 1'b0;
  logic       rx_in_valid = 1'b0;
  logic [7:0] rx_in_data = '0;
  logic [2:0] rx_in_err = '0;
  logic       tx_in_valid = 1'b0;
  logic [7:0] tx_in_data = '0;
  logic       rx_in_ready, rx_out_valid, tx_in_ready, tx_out_valid;
  logic [7:0] rx_out_data, tx_out_data;
  logic [2:0] rx_out_err;
  logic [5:0] rx_count, tx_count;
  logic       rx_trig, tx_trig, rx_dma_req, tx_dma_req, rx_tmo_irq, rx_overrun;
  logic       mon_rx = 1'b0, mon_tx = 1'b0, mon_rx_pop = 1'b0, mon_tx_pop = 1'b0;
  logic       force_rx = 1'b0;
  logic       rx_out_ready, tx_out_ready;
  logic       done = 1'b0;
  int         total = 0, bad = 0;
  logic [10:0] rx_q[$];
  logic [7:0]  tx_q[$];
  logic [7:0]  last_rx;

  assign rx_out_ready = mon_rx_pop || force_rx;
  assign tx_out_ready = mon_tx_pop;

  always #(CLK_PERIOD / 2) clk = ~clk;

  uart_chan_fifo dut_i (
    .clk, .rst_n, .fcr_wr, .fcr_data, .enh_en, .char_tick,
    .rx_in_valid, .rx_in_ready, .rx_in_data, .rx_in_err,
    .rx_out_valid, .rx_out_ready, .rx_out_data, .rx_out_err,
    .tx_in_valid, .tx_in_ready, .tx_in_data,
    .tx_out_valid, .tx_out_ready, .tx_out_data,
    .rx_count, .tx_count, .rx_trig, .tx_trig, .rx_dma_req, .tx_dma_req,
    .rx_tmo_irq, .rx_overrun
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fcr(input logic [7:0] v);
    fcr_wr = 1'b1; fcr_data = v;
    @(negedge clk);
    fcr_wr = 1'b0;
  endtask

  task automatic rx_push(input logic [7:0] d, input logic [2:0] e);
    if (rx_in_ready) rx_q.push_back({e, d});
    rx_in_valid = 1'b1; rx_in_data = d; rx_in_err = e;
    @(negedge clk);
    rx_in_valid = 1'b0;
  endtask

  task automatic tx_push(input logic [7:0] d);
    if (tx_in_ready) tx_q.push_back(d);
    tx_in_valid = 1'b1; tx_in_data = d;
    @(negedge clk);
    tx_in_valid = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      char_tick = 1'b1;
      @(negedge clk);
      char_tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic rx_force_pop();
    if (rx_out_valid && rx_q.size() > 0) begin
      chk("R3 forced pop data", {21'b0, rx_out_err, rx_out_data}, {21'b0, rx_q[0]});
      void'(rx_q.pop_front());
    end
    force_rx = 1'b1;
    @(negedge clk);
    force_rx = 1'b0;
  endtask

  // monitors: compare each popped item against the scoreboard queues
  always @(negedge clk) begin
    if (mon_rx && rx_out_valid) begin
      if (rx_q.size() == 0) chk("R3 rx unexpected item", {21'b0, rx_out_err, rx_out_data}, 32'hFFFF);
      else chk("R3 rx order", {21'b0, rx_out_err, rx_out_data}, {21'b0, rx_q.pop_front()});
      mon_rx_pop = 1'b1;
    end else mon_rx_pop = 1'b0;
    if (mon_tx && tx_out_valid) begin
      if (tx_q.size() == 0) chk("R3 tx unexpected item", {24'b0, tx_out_data}, 32'hFFFF);
      else chk("R3 tx order", {24'b0, tx_out_data}, {24'b0, tx_q.pop_front()});
      mon_tx_pop = 1'b1;
    end else mon_tx_pop = 1'b0;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 rx_count", rx_count, 0);
    chk("R10 tx_count", tx_count, 0);
    chk("R10 rx_trig", rx_trig, 0);
    chk("R10 tx_trig", tx_trig, 1);
    chk("R10 irq", rx_tmo_irq, 0);
    chk("R10 overrun", rx_overrun, 0);

    // R2 single-entry mode
    rx_push(8'h5A, 3'd1);
    chk("R2 rx one entry", rx_count, 1);
    chk("R2 rx trig at one", rx_trig, 1);
    chk("R2 rx full at one", rx_in_ready, 0);
    chk("R7 mode0 rx dma", rx_dma_req, 1);
    rx_push(8'h6B, 3'd2);
    chk("R2 rx second dropped", rx_count, 1);
    chk("R1 overrun on full", rx_overrun, 1);
    tx_push(8'h11);
    chk("R2 tx full at one", tx_in_ready, 0);
    chk("R2 tx trig off", tx_trig, 0);
    chk("R7 mode0 tx dma", tx_dma_req, 0);
    mon_rx = 1'b1;
    repeat (4) @(negedge clk);
    mon_rx = 1'b0;
    @(negedge clk);
    chk("R3 rx drained", rx_q.size(), 0);
    fcr(8'h09);
    tx_q.delete();
    chk("R2 mode change empties tx", tx_count, 0);
    chk("R8 mode change clears overrun", rx_overrun, 0);

    // R4 receive trigger levels
    for (int i = 0; i < 7; i++) rx_push(8'h10 + 8'(i), 3'(i));
    chk("R4 below 8", rx_trig, 0);
    rx_push(8'h17, 3'd7);
    chk("R4 at 8", rx_trig, 1);
    chk("R7 mode1 rx dma", rx_dma_req, 1);
    fcr(8'hC9);
    chk("R8 no flush on same mode", rx_count, 8);
    chk("R4 level 28 not met", rx_trig, 0);
    for (int i = 8; i < 27; i++) rx_push(8'h10 + 8'(i), 3'(i));
    chk("R4 at 27", rx_trig, 0);
    rx_push(8'h2B, 3'd3);
    chk("R4 at 28", rx_trig, 1);
    for (int i = 28; i < 32; i++) rx_push(8'h10 + 8'(i), 3'(i));
    chk("R1 rx full at 32", rx_in_ready, 0);
    rx_push(8'hEE, 3'd5);
    chk("R1 rx count stays 32", rx_count, 32);
    chk("R1 overrun at 32", rx_overrun, 1);
    mon_rx = 1'b1;
    repeat (40) @(negedge clk);
    mon_rx = 1'b0;
    @(negedge clk);
    chk("R3 rx all drained", rx_q.size(), 0);

    // R5 transmit trigger
    fcr(8'h39);
    for (int i = 0; i < 16; i++) tx_push(8'h40 + 8'(i));
    chk("R5 default 16 free", tx_trig, 1);
    tx_push(8'h50);
    chk("R5 15 free default", tx_trig, 0);
    enh_en = 1'b1;
    @(negedge clk);
    chk("R5 pending 30 active", tx_trig, 0);
    fcr(8'h3D);
    tx_q.delete();
    chk("R8 tx flush", tx_count, 0);
    tx_push(8'h61); tx_push(8'h62);
    chk("R5 30 free", tx_trig, 1);
    chk("R7 mode1 tx dma", tx_dma_req, 1);
    tx_push(8'h63);
    chk("R5 29 free", tx_trig, 0);
    enh_en = 1'b0;
    @(negedge clk);
    chk("R5 back to 16", tx_trig, 1);
    for (int i = 3; i < 32; i++) tx_push(8'h60 + 8'(i));
    chk("R1 tx full at 32", tx_in_ready, 0);
    tx_push(8'hFF);
    chk("R1 tx count 32", tx_count, 32);
    mon_tx = 1'b1;
    repeat (40) @(negedge clk);
    mon_tx = 1'b0;
    @(negedge clk);
    chk("R3 tx all drained", tx_q.size(), 0);

    // R6 timeout
    fcr(8'h3B);
    chk("R8 rx flush clears overrun", rx_overrun, 0);
    rx_push(8'hA1, 3'd0); rx_push(8'hA2, 3'd4); rx_push(8'hA3, 3'd6);
    tick(3);
    chk("R6 no irq after 3 ticks", rx_tmo_irq, 0);
    tick(1);
    chk("R6 irq after 4 ticks", rx_tmo_irq, 1);
    chk("R7 dma from timeout", rx_dma_req, 1);
    last_rx = rx_out_data;
    rx_force_pop();
    chk("R6 pop clears irq", rx_tmo_irq, 0);
    tick(3);
    chk("R6 restart after pop", rx_tmo_irq, 0);
    tick(1);
    chk("R6 irq again", rx_tmo_irq, 1);
    tx_push(8'h77);
    fcr(8'h3B);
    rx_q.delete();
    chk("R8 rx flush count", rx_count, 0);
    chk("R8 rx flush irq", rx_tmo_irq, 0);
    chk("R8 tx untouched", tx_count, 1);

    // R9 pop from empty
    chk("R9 last value shown", rx_out_data, last_rx);
    rx_force_pop();
    chk("R9 count unchanged", rx_count, 0);
    chk("R9 data unchanged", rx_out_data, last_rx);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule